// File: doc/BRIEF.md
# Receive Flow Steering Classifier with Transmit Merge

This block sits in a network interface between the header parser and the consumers of received packets. Each packet arrives as a valid/ready stream of data beats with a last-beat flag. The parsed header fields travel beside the first beat. The block sends the whole packet to exactly one destination. UDP traffic aimed at a configurable service port goes to a dedicated key-value lookup engine. All other traffic goes to one of `NQ` per-core software receive queues, selected by a flow hash.

The receive side is a two-state machine. In `RX_IDLE` it classifies the first beat from the live header. A first beat that is not also the last beat moves it to `RX_BODY` (transition IDLE→BODY), where the latched choice steers the rest of the packet. The last beat returns it to `RX_IDLE` (transition BODY→IDLE). The service port is written through a one-cycle configuration strobe. The value is staged and only becomes active between packets.

The transmit side merges two packet streams onto one output: the software descriptor path and the lookup engine's replies. It is a three-state machine. `TX_IDLE` picks a source round-robin. `TX_SW` and `TX_ACC` lock the output to that source until its last beat (transitions IDLE→SW, IDLE→ACC on a non-last first beat, and SW→IDLE, ACC→IDLE on the last beat).

Top module: `rxs_steer_top`

## Requirements
- R1: After reset, `acc_valid`, every bit of `q_valid` and `tx_valid` are low, and the active service port equals parameter `SVC_RESET` (default 9000).
- R2: A first beat with `rx_is_ip`=1, `rx_proto`=17 (UDP) and `rx_dst_port` equal to the active service port goes to the accelerator output and to no queue.
- R3: A first beat with `rx_proto`=6 (TCP) addressed to the service port goes to the hashed software queue, never to the accelerator.
- R4: For TCP or UDP packets not bound to the accelerator, the queue index is the XOR of all consecutive log2(NQ)-bit slices, starting at bit 0, of `rx_src_ip ^ rx_dst_ip ^ {rx_src_port, rx_dst_port}` (zero-padded at the top).
- R5: A first beat with `rx_is_ip`=0, or with a protocol other than 6 or 17, goes to queue 0.
- R6: Every beat of a packet follows the destination chosen on its first beat, and two packets with the same header fields reach the same queue.
- R7: The selected destination's ready drives `rx_ready`. Output data and last flags equal the input ones, and nothing is lost or duplicated under back-pressure.
- R8: A service-port write is staged. It becomes active at the first clock edge where either no packet is in progress and `rx_valid` is low, or a last beat is accepted. A packet in flight keeps its destination.
- R9: At the start of a packet, if both transmit sources are valid, the one not served last wins, with software first after reset. A lone valid source is always granted.
- R10: Once a transmit packet's first beat is accepted, only that source is served until its last beat is accepted.
- R11: Only the granted source sees `tx_ready` on its ready output. The other source's ready stays low, and `tx_valid`/`tx_data`/`tx_last` follow the granted source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Service-port write strobe |
| cfg_svc_port | input | 16 | Service-port write value |
| rx_valid | input | 1 | Receive beat valid |
| rx_ready | output | 1 | Receive beat accepted |
| rx_data | input | DW | Receive beat data |
| rx_last | input | 1 | Final beat of the packet |
| rx_is_ip | input | 1 | Frame carries IPv4 (first beat) |
| rx_proto | input | 8 | IP protocol number (first beat) |
| rx_src_ip | input | 32 | Source address (first beat) |
| rx_dst_ip | input | 32 | Destination address (first beat) |
| rx_src_port | input | 16 | Transport source port (first beat) |
| rx_dst_port | input | 16 | Transport destination port (first beat) |
| acc_valid | output | 1 | Accelerator beat valid |
| acc_ready | input | 1 | Accelerator can accept |
| acc_data | output | DW | Accelerator beat data |
| acc_last | output | 1 | Accelerator final beat |
| q_valid | output | NQ | Per-queue beat valid |
| q_ready | input | NQ | Per-queue ready |
| q_data | output | DW | Shared queue beat data |
| q_last | output | 1 | Shared queue final beat |
| sw_tx_valid | input | 1 | Software transmit beat valid |
| sw_tx_ready | output | 1 | Software transmit beat accepted |
| sw_tx_data | input | DW | Software transmit data |
| sw_tx_last | input | 1 | Software transmit final beat |
| acc_tx_valid | input | 1 | Accelerator transmit beat valid |
| acc_tx_ready | output | 1 | Accelerator transmit beat accepted |
| acc_tx_data | input | DW | Accelerator transmit data |
| acc_tx_last | input | 1 | Accelerator transmit final beat |
| tx_valid | output | 1 | Merged transmit valid |
| tx_ready | input | 1 | Merged transmit ready |
| tx_data | output | DW | Merged transmit data |
| tx_last | output | 1 | Merged transmit final beat |

## Verification
A service-port write can arrive in the same cycle as packet traffic: mid-packet, or while a first beat is stalled. A stale or early change then flips where a packet goes. The bench provokes this by writing a new port while a long UDP packet to the old port is in flight under toggling accelerator ready. It then checks three things: the in-flight packet stays on the accelerator, a following UDP packet to the new port reaches the accelerator, and one to the old port is hashed to a queue. A cycle-by-cycle model holds both the staged and the active port, and compares every valid, ready and data output on each clock.

// File: rtl/rxs_pkg.sv
`timescale 1ns/1ps
package rxs_pkg;

    localparam logic [7:0] PROTO_TCP = 8'd6;
    localparam logic [7:0] PROTO_UDP = 8'd17;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_BODY = 1'b1
    } rx_state_e;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_SW   = 2'd1,
        TX_ACC  = 2'd2
    } tx_state_e;

endpackage

// File: rtl/rxs_flow_hash.sv
`timescale 1ns/1ps
module rxs_flow_hash #(
    parameter int NQ = 4,
    localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic [31:0]   src_ip,
    input  logic [31:0]   dst_ip,
    input  logic [15:0]   src_port,
    input  logic [15:0]   dst_port,
    output logic [QW-1:0] qidx
);
    localparam int NS = (32 + QW - 1) / QW;

    logic [31:0]      mix;
    logic [NS*QW-1:0] padded;
    logic [QW-1:0]    part [0:NS];

    always_comb begin
        mix    = src_ip ^ dst_ip ^ {src_port, dst_port};
        padded = '0;
        padded[31:0] = mix;
    end

    assign part[0] = '0;
    for (genvar g = 0; g < NS; g++) begin : g_fold
        assign part[g+1] = part[g] ^ padded[g*QW +: QW];
    end

    assign qidx = part[NS];

endmodule

// File: rtl/rxs_rx_classifier.sv
`timescale 1ns/1ps
module rxs_rx_classifier import rxs_pkg::*; #(
    parameter int          NQ        = 4,
    parameter int          DW        = 32,
    parameter logic [15:0] SVC_RESET = 16'd9000,
    localparam int         QW        = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr_en,
    input  logic [15:0]   cfg_svc_port,
    input  logic          rx_valid,
    output logic          rx_ready,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_last,
    input  logic          rx_is_ip,
    input  logic [7:0]    rx_proto,
    input  logic [15:0]   rx_dst_port,
    input  logic [QW-1:0] hash_q,
    output logic          acc_valid,
    input  logic          acc_ready,
    output logic [DW-1:0] acc_data,
    output logic          acc_last,
    output logic [NQ-1:0] q_valid,
    input  logic [NQ-1:0] q_ready,
    output logic [DW-1:0] q_data,
    output logic          q_last
);
    rx_state_e     state, state_nx;
    logic [15:0]   svc_port;
    logic [15:0]   pend_port;
    logic          pend_vld;
    logic          held_acc;
    logic [QW-1:0] held_q;
    logic          live_acc;
    logic [QW-1:0] live_q;
    logic          sel_acc;
    logic [QW-1:0] sel_q;
    logic          beat;
    logic          commit;
    logic          l4_known;

    // live decision from the first-beat header
    always_comb begin
        l4_known = rx_is_ip && ((rx_proto == PROTO_TCP) || (rx_proto == PROTO_UDP));
        live_acc = rx_is_ip && (rx_proto == PROTO_UDP) && (rx_dst_port == svc_port);
        live_q   = l4_known ? hash_q : '0;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RX_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state and steering outputs
    always_comb begin
        state_nx = state;
        sel_acc  = live_acc;
        sel_q    = live_q;
        beat     = 1'b0;
        unique case (state)
            RX_IDLE: begin
                sel_acc = live_acc;
                sel_q   = live_q;
            end
            RX_BODY: begin
                sel_acc = held_acc;
                sel_q   = held_q;
            end
        endcase
        rx_ready  = sel_acc ? acc_ready : q_ready[sel_q];
        beat      = rx_valid && rx_ready;
        acc_valid = rx_valid && sel_acc;
        for (int i = 0; i < NQ; i++) begin
            q_valid[i] = rx_valid && !sel_acc && (sel_q == QW'(i));
        end
        acc_data = rx_data;
        acc_last = rx_last;
        q_data   = rx_data;
        q_last   = rx_last;
        unique case (state)
            RX_IDLE: if (beat && !rx_last) state_nx = RX_BODY;
            RX_BODY: if (beat && rx_last)  state_nx = RX_IDLE;
        endcase
    end

    // latched destination for the rest of a packet
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_acc <= 1'b0;
            held_q   <= '0;
        end else if (state == RX_IDLE && beat) begin
            held_acc <= live_acc;
            held_q   <= live_q;
        end
    end

    // service port staging: commit only between packets
    assign commit = ((state == RX_IDLE) && !rx_valid) || (beat && rx_last);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            svc_port  <= SVC_RESET;
            pend_port <= SVC_RESET;
            pend_vld  <= 1'b0;
        end else if (cfg_wr_en) begin
            pend_port <= cfg_svc_port;
            pend_vld  <= 1'b1;
        end else if (commit && pend_vld) begin
            svc_port <= pend_port;
            pend_vld <= 1'b0;
        end
    end

    AST_RX_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n) (rx_valid && rx_ready) |-> ((acc_valid && acc_ready) || (|(q_valid & q_ready)))); // R7
    AST_ACC_PKT_STAYS: assert property (@(posedge clk) disable iff (!rst_n) (acc_valid && acc_ready && !acc_last) |=> !(|q_valid)); // R6
    AST_Q_PKT_STAYS: assert property (@(posedge clk) disable iff (!rst_n) ((|(q_valid & q_ready)) && !q_last) |=> !acc_valid); // R6
    AST_SVC_HELD: assert property (@(posedge clk) disable iff (!rst_n) (state == RX_BODY && !(beat && rx_last)) |=> $stable(svc_port)); // R8
    AST_NONIP_Q0: assert property (@(posedge clk) disable iff (!rst_n) (state == RX_IDLE && rx_valid && !rx_is_ip) |-> (q_valid == NQ'(1) && !acc_valid)); // R5
    AST_TCP_NOT_ACC: assert property (@(posedge clk) disable iff (!rst_n) (state == RX_IDLE && rx_valid && rx_proto == PROTO_TCP) |-> !acc_valid); // R3

endmodule

// File: rtl/rxs_tx_merge.sv
`timescale 1ns/1ps
module rxs_tx_merge import rxs_pkg::*; #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_tx_valid,
    output logic          sw_tx_ready,
    input  logic [DW-1:0] sw_tx_data,
    input  logic          sw_tx_last,
    input  logic          acc_tx_valid,
    output logic          acc_tx_ready,
    input  logic [DW-1:0] acc_tx_data,
    input  logic          acc_tx_last,
    output logic          tx_valid,
    input  logic          tx_ready,
    output logic [DW-1:0] tx_data,
    output logic          tx_last
);
    tx_state_e state, state_nx;
    logic      prefer_acc;
    logic      grant_sw;
    logic      grant_acc;
    logic      hs;

    // state register and round-robin pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= TX_IDLE;
            prefer_acc <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == TX_IDLE && hs) begin
                prefer_acc <= grant_sw;
            end
        end
    end

    // grant, output mux and next state
    always_comb begin
        grant_sw  = 1'b0;
        grant_acc = 1'b0;
        state_nx  = state;
        unique case (state)
            TX_IDLE: begin
                if (sw_tx_valid && acc_tx_valid) begin
                    grant_acc = prefer_acc;
                    grant_sw  = !prefer_acc;
                end else begin
                    grant_sw  = sw_tx_valid;
                    grant_acc = acc_tx_valid;
                end
            end
            TX_SW:  grant_sw  = 1'b1;
            TX_ACC: grant_acc = 1'b1;
            default: begin
                grant_sw  = 1'b0;
                grant_acc = 1'b0;
            end
        endcase
        tx_valid     = (grant_sw && sw_tx_valid) || (grant_acc && acc_tx_valid);
        tx_data      = grant_acc ? acc_tx_data : sw_tx_data;
        tx_last      = grant_acc ? acc_tx_last : sw_tx_last;
        sw_tx_ready  = grant_sw && tx_ready;
        acc_tx_ready = grant_acc && tx_ready;
        hs           = tx_valid && tx_ready;
        unique case (state)
            TX_IDLE: if (hs && !tx_last) state_nx = grant_acc ? TX_ACC : TX_SW;
            TX_SW:   if (hs && tx_last)  state_nx = TX_IDLE;
            TX_ACC:  if (hs && tx_last)  state_nx = TX_IDLE;
            default: state_nx = TX_IDLE;
        endcase
    end

    AST_TX_LOCK_SW: assert property (@(posedge clk) disable iff (!rst_n) (state == TX_SW) |-> !acc_tx_ready); // R10
    AST_TX_LOCK_ACC: assert property (@(posedge clk) disable iff (!rst_n) (state == TX_ACC) |-> !sw_tx_ready); // R10
    AST_TX_STALL: assert property (@(posedge clk) disable iff (!rst_n) (tx_valid && !tx_ready) |-> (!sw_tx_ready && !acc_tx_ready)); // R11
    AST_TX_ONE_READY: assert property (@(posedge clk) disable iff (!rst_n) !(sw_tx_ready && acc_tx_ready)); // R11
    AST_TX_RR_TURN: assert property (@(posedge clk) disable iff (!rst_n) (state == TX_IDLE && sw_tx_valid && sw_tx_ready && sw_tx_last) |=> (state == TX_IDLE && sw_tx_valid && acc_tx_valid) |-> acc_tx_ready == tx_ready); // R9

endmodule

// File: rtl/rxs_steer_top.sv
`timescale 1ns/1ps
module rxs_steer_top #(
    parameter int          NQ        = 4,
    parameter int          DW        = 32,
    parameter logic [15:0] SVC_RESET = 16'd9000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr_en,
    input  logic [15:0]   cfg_svc_port,
    input  logic          rx_valid,
    output logic          rx_ready,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_last,
    input  logic          rx_is_ip,
    input  logic [7:0]    rx_proto,
    input  logic [31:0]   rx_src_ip,
    input  logic [31:0]   rx_dst_ip,
    input  logic [15:0]   rx_src_port,
    input  logic [15:0]   rx_dst_port,
    output logic          acc_valid,
    input  logic          acc_ready,
    output logic [DW-1:0] acc_data,
    output logic          acc_last,
    output logic [NQ-1:0] q_valid,
    input  logic [NQ-1:0] q_ready,
    output logic [DW-1:0] q_data,
    output logic          q_last,
    input  logic          sw_tx_valid,
    output logic          sw_tx_ready,
    input  logic [DW-1:0] sw_tx_data,
    input  logic          sw_tx_last,
    input  logic          acc_tx_valid,
    output logic          acc_tx_ready,
    input  logic [DW-1:0] acc_tx_data,
    input  logic          acc_tx_last,
    output logic          tx_valid,
    input  logic          tx_ready,
    output logic [DW-1:0] tx_data,
    output logic          tx_last
);
    localparam int QW = (NQ > 1) ? $clog2(NQ) : 1;

    logic [QW-1:0] hash_q;

    rxs_flow_hash #(.NQ(NQ)) i_hash (
        .src_ip   (rx_src_ip),
        .dst_ip   (rx_dst_ip),
        .src_port (rx_src_port),
        .dst_port (rx_dst_port),
        .qidx     (hash_q)
    );

    rxs_rx_classifier #(.NQ(NQ), .DW(DW), .SVC_RESET(SVC_RESET)) i_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr_en    (cfg_wr_en),
        .cfg_svc_port (cfg_svc_port),
        .rx_valid     (rx_valid),
        .rx_ready     (rx_ready),
        .rx_data      (rx_data),
        .rx_last      (rx_last),
        .rx_is_ip     (rx_is_ip),
        .rx_proto     (rx_proto),
        .rx_dst_port  (rx_dst_port),
        .hash_q       (hash_q),
        .acc_valid    (acc_valid),
        .acc_ready    (acc_ready),
        .acc_data     (acc_data),
        .acc_last     (acc_last),
        .q_valid      (q_valid),
        .q_ready      (q_ready),
        .q_data       (q_data),
        .q_last       (q_last)
    );

    rxs_tx_merge #(.DW(DW)) i_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .sw_tx_valid  (sw_tx_valid),
        .sw_tx_ready  (sw_tx_ready),
        .sw_tx_data   (sw_tx_data),
        .sw_tx_last   (sw_tx_last),
        .acc_tx_valid (acc_tx_valid),
        .acc_tx_ready (acc_tx_ready),
        .acc_tx_data  (acc_tx_data),
        .acc_tx_last  (acc_tx_last),
        .tx_valid     (tx_valid),
        .tx_ready     (tx_ready),
        .tx_data      (tx_data),
        .tx_last      (tx_last)
    );

endmodule

// File: tb/test_rxs_steer_top.sv
`timescale 1ns/1ps
module test_rxs_steer_top;
    localparam int NQ = 4;
    localparam int QW = 2;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr_en = 1'b0;
    logic [15:0]   cfg_svc_port = '0;
    logic          rx_valid = 1'b0;
    logic          rx_ready;
    logic [DW-1:0] rx_data = '0;
    logic          rx_last = 1'b0;
    logic          rx_is_ip = 1'b0;
    logic [7:0]    rx_proto = '0;
    logic [31:0]   rx_src_ip = '0;
    logic [31:0]   rx_dst_ip = '0;
    logic [15:0]   rx_src_port = '0;
    logic [15:0]   rx_dst_port = '0;
    logic          acc_valid;
    logic          acc_ready = 1'b0;
    logic [DW-1:0] acc_data;
    logic          acc_last;
    logic [NQ-1:0] q_valid;
    logic [NQ-1:0] q_ready = '0;
    logic [DW-1:0] q_data;
    logic          q_last;
    logic          sw_tx_valid = 1'b0;
    logic          sw_tx_ready;
    logic [DW-1:0] sw_tx_data = '0;
    logic          sw_tx_last = 1'b0;
    logic          acc_tx_valid = 1'b0;
    logic          acc_tx_ready;
    logic [DW-1:0] acc_tx_data = '0;
    logic          acc_tx_last = 1'b0;
    logic          tx_valid;
    logic          tx_ready = 1'b0;
    logic [DW-1:0] tx_data;
    logic          tx_last;

    always #10 clk = ~clk;

    rxs_steer_top #(.NQ(NQ), .DW(DW), .SVC_RESET(16'd9000)) i_rxs_steer_top (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_svc_port(cfg_svc_port),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_last(rx_last),
        .rx_is_ip(rx_is_ip), .rx_proto(rx_proto), .rx_src_ip(rx_src_ip), .rx_dst_ip(rx_dst_ip),
        .rx_src_port(rx_src_port), .rx_dst_port(rx_dst_port),
        .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_data(acc_data), .acc_last(acc_last),
        .q_valid(q_valid), .q_ready(q_ready), .q_data(q_data), .q_last(q_last),
        .sw_tx_valid(sw_tx_valid), .sw_tx_ready(sw_tx_ready), .sw_tx_data(sw_tx_data), .sw_tx_last(sw_tx_last),
        .acc_tx_valid(acc_tx_valid), .acc_tx_ready(acc_tx_ready), .acc_tx_data(acc_tx_data), .acc_tx_last(acc_tx_last),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int rdy_mode = 0;

    // receive packet queue
    logic        p_isip [$];
    logic [7:0]  p_proto [$];
    logic [31:0] p_sip [$];
    logic [31:0] p_dip [$];
    logic [15:0] p_sport [$];
    logic [15:0] p_dport [$];
    int          p_len [$];
    int          p_exp [$];
    string       p_tag [$];
    int          p_id [$];
    int          next_id = 0;
    int          got [int];

    bit          cur_v = 0;
    int          cur_beat, cur_len, cur_exp, cur_id, first_dest;
    string       cur_tag;

    // transmit sources
    int sw_lens [$];
    int ac_lens [$];
    bit sw_v = 0, ac_v = 0;
    int sw_beat, sw_len, sw_id = 0, ac_beat, ac_len, ac_id = 0;
    logic [7:0] glog [$];
    bit tx_first = 1;
    logic [7:0] tx_src;

    // reference model state
    bit          m_body = 0;
    int          m_dest = 0;
    logic [15:0] m_svc = 16'd9000;
    logic [15:0] m_pval = 16'd9000;
    bit          m_pend = 0;
    int          m_lock = 0;
    bit          m_pref_acc = 0;

    bit          cfg_req = 0;
    logic [15:0] cfg_val = '0;

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    function automatic int route(logic isip, logic [7:0] proto, logic [31:0] sip, logic [31:0] dip,
                                 logic [15:0] sport, logic [15:0] dport, logic [15:0] svc);
        logic [31:0] h;
        int q;
        if (isip && proto == 8'd17 && dport == svc) return -1;
        if (!isip || (proto != 8'd6 && proto != 8'd17)) return 0;
        h = sip ^ dip ^ {sport, dport};
        q = 0;
        for (int i = 0; i < 32; i++) q = q ^ (int'(h[i]) << (i % QW));
        return q;
    endfunction

    function automatic int add_pkt(logic isip, logic [7:0] proto, logic [31:0] sip, logic [31:0] dip,
                                   logic [15:0] sport, logic [15:0] dport, int len, logic [15:0] svc, string tag);
        p_isip.push_back(isip); p_proto.push_back(proto); p_sip.push_back(sip); p_dip.push_back(dip);
        p_sport.push_back(sport); p_dport.push_back(dport); p_len.push_back(len);
        p_exp.push_back(route(isip, proto, sip, dip, sport, dport, svc));
        p_tag.push_back(tag); p_id.push_back(next_id);
        next_id++;
        return next_id - 1;
    endfunction

    task automatic step();
        int ed, pick, ad;
        logic [NQ-1:0] exp_qv;
        logic exp_av, exp_rdy, exp_tv, exp_tl, exp_swr, exp_acr, rhs, mhs_rx, mhs_tx, commit;
        logic [DW-1:0] exp_td;
        @(negedge clk);
        cyc++;
        if (!cur_v && p_len.size() > 0) begin
            rx_is_ip = p_isip.pop_front(); rx_proto = p_proto.pop_front();
            rx_src_ip = p_sip.pop_front(); rx_dst_ip = p_dip.pop_front();
            rx_src_port = p_sport.pop_front(); rx_dst_port = p_dport.pop_front();
            cur_len = p_len.pop_front(); cur_exp = p_exp.pop_front();
            cur_tag = p_tag.pop_front(); cur_id = p_id.pop_front();
            cur_v = 1; cur_beat = 0;
        end
        rx_valid = cur_v;
        rx_data  = {8'(cur_id), 24'(cur_beat)};
        rx_last  = cur_v && (cur_beat == cur_len - 1);
        if (rdy_mode == 0) begin
            q_ready = '1; acc_ready = 1'b1; tx_ready = 1'b1;
        end else begin
            for (int i = 0; i < NQ; i++) q_ready[i] = ((cyc + i) % 3) != 0;
            acc_ready = (cyc % 4) != 1;
            tx_ready  = (cyc % 5) != 2;
        end
        if (!sw_v && sw_lens.size() > 0) begin sw_len = sw_lens.pop_front(); sw_v = 1; sw_beat = 0; sw_id++; end
        if (!ac_v && ac_lens.size() > 0) begin ac_len = ac_lens.pop_front(); ac_v = 1; ac_beat = 0; ac_id++; end
        sw_tx_valid = sw_v; sw_tx_data = {8'h51, 8'(sw_id), 16'(sw_beat)}; sw_tx_last = sw_v && (sw_beat == sw_len - 1);
        acc_tx_valid = ac_v; acc_tx_data = {8'hA7, 8'(ac_id), 16'(ac_beat)}; acc_tx_last = ac_v && (ac_beat == ac_len - 1);
        cfg_wr_en = cfg_req; cfg_svc_port = cfg_val; cfg_req = 0;
        #1;
        // receive model compare
        ed = m_body ? m_dest : route(rx_is_ip, rx_proto, rx_src_ip, rx_dst_ip, rx_src_port, rx_dst_port, m_svc);
        exp_av = rx_valid && (ed == -1);
        for (int i = 0; i < NQ; i++) exp_qv[i] = rx_valid && (ed == i);
        exp_rdy = (ed == -1) ? acc_ready : q_ready[ed];
        chk(acc_valid === exp_av && q_valid === exp_qv && (!rx_valid || rx_ready === exp_rdy)
            && (!acc_valid || (acc_data === rx_data && acc_last === rx_last))
            && (!(|q_valid) || (q_data === rx_data && q_last === rx_last)),
            "R7", {acc_valid, q_valid, rx_ready}, {exp_av, exp_qv, exp_rdy});
        // transmit model compare
        if (m_lock != 0) pick = m_lock;
        else if (sw_tx_valid && acc_tx_valid) pick = m_pref_acc ? 2 : 1;
        else if (sw_tx_valid) pick = 1;
        else if (acc_tx_valid) pick = 2;
        else pick = 0;
        exp_tv  = (pick == 1) ? sw_tx_valid : (pick == 2) ? acc_tx_valid : 1'b0;
        exp_td  = (pick == 2) ? acc_tx_data : sw_tx_data;
        exp_tl  = (pick == 2) ? acc_tx_last : sw_tx_last;
        exp_swr = (pick == 1) && tx_ready;
        exp_acr = (pick == 2) && tx_ready;
        chk(tx_valid === exp_tv && sw_tx_ready === exp_swr && acc_tx_ready === exp_acr
            && (!tx_valid || (tx_data === exp_td && tx_last === exp_tl)),
            "R11", {tx_valid, sw_tx_ready, acc_tx_ready, tx_data}, {exp_tv, exp_swr, exp_acr, exp_td});
        // observed receive handshakes
        rhs = rx_valid && rx_ready;
        if (rhs) begin
            ad = -2;
            if (acc_valid && acc_ready) ad = -1;
            for (int i = 0; i < NQ; i++) if (q_valid[i] && q_ready[i]) ad = i;
            if (cur_beat == 0) begin
                chk(ad == cur_exp, cur_tag, 64'(ad), 64'(cur_exp));
                first_dest = ad;
                got[cur_id] = ad;
            end else begin
                chk(ad == first_dest, "R6", 64'(ad), 64'(first_dest));
            end
        end
        if (tx_valid && tx_ready) begin
            if (tx_first) begin
                glog.push_back(tx_data[31:24]);
                tx_src = tx_data[31:24];
            end else begin
                chk(tx_data[31:24] == tx_src, "R10", 64'(tx_data[31:24]), 64'(tx_src));
            end
            tx_first = tx_last;
        end
        mhs_rx = rx_valid && exp_rdy;
        mhs_tx = exp_tv && tx_ready;
        commit = (!m_body && !rx_valid) || (mhs_rx && rx_last);
        @(posedge clk);
        if (cfg_wr_en) begin m_pend = 1; m_pval = cfg_svc_port; end
        else if (commit && m_pend) begin m_svc = m_pval; m_pend = 0; end
        if (mhs_rx) begin
            if (!m_body && !rx_last) begin m_body = 1; m_dest = ed; end
            else if (m_body && rx_last) m_body = 0;
        end
        if (m_lock == 0 && mhs_tx) begin
            m_pref_acc = (pick == 1);
            if (!exp_tl) m_lock = pick;
        end else if (m_lock != 0 && mhs_tx && exp_tl) begin
            m_lock = 0;
        end
        if (rhs) begin if (rx_last) cur_v = 0; else cur_beat++; end
        if (sw_tx_valid && sw_tx_ready) begin if (sw_tx_last) sw_v = 0; else sw_beat++; end
        if (acc_tx_valid && acc_tx_ready) begin if (acc_tx_last) ac_v = 0; else ac_beat++; end
    endtask

    task automatic drain();
        int n = 0;
        while (p_len.size() > 0 || cur_v || sw_lens.size() > 0 || ac_lens.size() > 0 || sw_v || ac_v) begin
            step();
            n++;
            if (n > 5000) begin
                chk(0, "WATCHDOG drain", 64'(n), 64'(5000));
                return;
            end
        end
        for (int k = 0; k < 3; k++) step();
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL WATCHDOG run did not finish act=%0d exp=0", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int a, b, c, d, id0, id1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state of every output valid
        chk(acc_valid === 1'b0, "R1", 64'(acc_valid), 0);
        chk(q_valid === '0, "R1", 64'(q_valid), 0);
        chk(tx_valid === 1'b0, "R1", 64'(tx_valid), 0);

        // phase A: free-flowing destinations
        rdy_mode = 0;
        a = add_pkt(1, 8'd17, 32'h0A000001, 32'h0A000002, 16'd1234, 16'd9000, 3, 16'd9000, "R2");
        a = add_pkt(1, 8'd6,  32'h0A000001, 32'h0A000002, 16'd1234, 16'd9000, 2, 16'd9000, "R3");
        a = add_pkt(1, 8'd17, 32'hC0A80105, 32'h0A000002, 16'd5353, 16'd53,   1, 16'd9000, "R4");
        id0 = add_pkt(1, 8'd6, 32'h11223344, 32'h55667788, 16'd40000, 16'd80, 2, 16'd9000, "R4");
        a = add_pkt(1, 8'd6,  32'h11223345, 32'h55667788, 16'd40000, 16'd80, 2, 16'd9000, "R4");
        a = add_pkt(1, 8'd6,  32'hDEADBEEF, 32'h01020304, 16'd7,     16'd443,3, 16'd9000, "R4");
        a = add_pkt(0, 8'd17, 32'h0,        32'h0,        16'd0,     16'd9000, 2, 16'd9000, "R5");
        a = add_pkt(1, 8'd1,  32'hFFFFFFFF, 32'h0000000F, 16'd1,     16'd2,   1, 16'd9000, "R5");
        id1 = add_pkt(1, 8'd6, 32'h11223344, 32'h55667788, 16'd40000, 16'd80, 3, 16'd9000, "R4");
        drain();
        chk(got.exists(id0) && got.exists(id1) && got[id0] == got[id1], "R6",
            64'(got[id1]), 64'(got[id0]));

        // phase B: back-pressure on every destination
        rdy_mode = 1;
        for (int k = 0; k < 6; k++) begin
            a = add_pkt(1, 8'd6,  32'h0A0000F0 + 32'(k * 37), 32'h0A000002, 16'(1000 + k), 16'd9000, 2 + k % 3, 16'd9000, "R3");
            a = add_pkt(1, 8'd17, 32'h0A0000F0 + 32'(k), 32'h0A000002, 16'(2000 + k), 16'd9000, 1 + k % 4, 16'd9000, "R2");
            a = add_pkt(1, 8'd17, 32'h10000000 + 32'(k * 911), 32'h20000000, 16'(3000 + k), 16'(100 + k), 2, 16'd9000, "R4");
        end
        drain();

        // phase C: service-port write while a packet to the old port is in flight
        a = add_pkt(1, 8'd17, 32'h0A000009, 32'h0A000002, 16'd4444, 16'd9000, 8, 16'd9000, "R8");
        step(); step(); step();
        cfg_req = 1; cfg_val = 16'd7000;
        step();
        b = add_pkt(1, 8'd17, 32'h0A000009, 32'h0A000002, 16'd4444, 16'd7000, 2, 16'd7000, "R8");
        c = add_pkt(1, 8'd17, 32'h0A000009, 32'h0A000002, 16'd4444, 16'd9000, 2, 16'd7000, "R8");
        d = add_pkt(1, 8'd6,  32'h0A000009, 32'h0A000002, 16'd4444, 16'd7000, 2, 16'd7000, "R3");
        drain();
        chk(got[a] == -1, "R8", 64'(got[a]), 64'hFFFFFFFFFFFFFFFF);
        chk(got[b] == -1, "R8", 64'(got[b]), 64'hFFFFFFFFFFFFFFFF);
        chk(got[c] >= 0, "R8", 64'(got[c]), 0);
        chk(got[d] >= 0, "R3", 64'(got[d]), 0);

        // phase D: transmit merge with both sources loaded, stalling output
        glog.delete();
        sw_lens = '{2, 3, 1};
        ac_lens = '{2, 1, 3};
        drain();
        chk(glog.size() == 6, "R9", 64'(glog.size()), 6);
        for (int k = 0; k < 6 && k < glog.size(); k++)
            chk(glog[k] == ((k % 2 == 0) ? 8'h51 : 8'hA7), "R9", 64'(glog[k]), (k % 2 == 0) ? 64'h51 : 64'hA7);

        // phase E: a lone source is granted back to back
        glog.delete();
        ac_lens = '{1, 2};
        drain();
        chk(glog.size() == 2 && glog[0] == 8'hA7 && glog[1] == 8'hA7, "R9", 64'(glog.size()), 2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule